// File: doc/BRIEF.md
# Decade Range Divider

This block turns a fast synthesizer clock into a slower reference tick whose rate can be set in steps of one decade. A chain of decade stages counts source cycles. Each stage is a divide-by-2 counter followed by a divide-by-5 counter. The undivided source and the carry of every stage form a set of taps, and each tap is ten times slower than the one before it.

A binary range code picks one tap. The chosen tap drives a final divide-by-5 counter, and that counter issues the reference tick that paces a waveform address counter downstream.

All logic runs on the source clock and uses clock enables, so the block contains no derived clocks. A new range code takes effect only when the final counter wraps. Each tick period therefore belongs wholly to a single range, and no runt periods appear on the output.

Top module: `decade_range_divider`

## Requirements
- R1: With range code 0 the undivided source drives the final stage, so `refTick` pulses once every 5 source cycles.
- R2: Range code k selects the carry of decade stage k, which fires once every 10^k source cycles, so `refTick` pulses once every 5·10^k source cycles.
- R3: Decade stage k advances only on cycles where every stage below it is at terminal count. After reset, the tap for code k therefore fires on the source cycles whose 1-based index since reset release is a multiple of 10^k.
- R4: Each decade stage is a divide-by-2 counter that enables a divide-by-5 counter. The stage is at terminal count when both counters hold their last values. Neither counter moves unless the stage below carries.
- R5: The final counter divides the selected tap by 5. `refTick` is asserted in the cycle after the tap event that takes the counter from 4 back to 0.
- R6: The range code is sampled only on the tap event that wraps the final counter. A code change at any other time has no effect until that event. The first period after a change is measured with the new code, from that event to the fifth following event of the newly selected tap.
- R7: While `rst` is high at a clock edge, every stage counter and the final counter clear to zero and the range code is loaded directly. The first `refTick` then follows source edge 5·10^k after release, where k is the code held during reset.
- R8: `refTick` is low while reset is applied. Each `refTick` pulse is exactly one source cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock from the synthesizer loop |
| rst | input | 1 | Synchronous reset, active high |
| rangeSel | input | SEL_W ($clog2(NUM_STAGES+1)) | Binary range code, 0 = undivided source |
| refTick | output | 1 | One-cycle reference clock-enable pulse |

## Verification
The assertions assume a clock that runs without gaps and a reset that is sampled on at least one edge. The stage and final-counter checks are disabled on the edges where the clear strobe is high. They accept a range code that changes on any cycle, because the block latches it only when the final counter wraps. The stimulus changes the code shortly after a rising edge, sometimes mid-period and sometimes just after a tick, and holds reset for three edges. The bench predicts each tick edge from the code it captured at that edge and the tick position: the next tick comes on the fifth multiple of 10^k after the current one.

// File: rtl/drd_pkg.sv
package drd_pkg;

  // Strobes issued by the control half to the counting datapath
  typedef struct packed {
    logic clear;  // synchronous clear of every counter
    logic step;   // advance the final divide counter this cycle
  } dpStrobe_t;

endpackage

// File: rtl/drd_decade_stage.sv
module drd_decade_stage #(
  parameter int LOW_DIV  = 2,
  parameter int HIGH_DIV = 5,
  localparam int LOW_W   = (LOW_DIV  > 1) ? $clog2(LOW_DIV)  : 1,
  localparam int HIGH_W  = (HIGH_DIV > 1) ? $clog2(HIGH_DIV) : 1
) (
  input  logic clk,
  input  logic clear,
  input  logic advance,
  output logic atTerm
);

  logic [LOW_W-1:0]  lowCnt;
  logic [HIGH_W-1:0] highCnt;
  logic lowLast, highLast;

  assign lowLast  = (lowCnt  == LOW_W'(LOW_DIV - 1));
  assign highLast = (highCnt == HIGH_W'(HIGH_DIV - 1));
  assign atTerm   = lowLast && highLast;

  always_ff @(posedge clk) begin
    if (clear) begin
      lowCnt <= '0;
    end else if (advance) begin
      lowCnt <= lowLast ? '0 : lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      highCnt <= '0;
    end else if (advance && lowLast) begin
      highCnt <= highLast ? '0 : highCnt + 1'b1;
    end
  end

  // R4
  high_range_chk: assert property (@(posedge clk) disable iff (clear)
    int'(highCnt) < HIGH_DIV);

  // R4
  stage_hold_chk: assert property (@(posedge clk) disable iff (clear)
    !advance |=> $stable({lowCnt, highCnt}));

  // R3
  stage_wrap_chk: assert property (@(posedge clk) disable iff (clear)
    (advance && atTerm) |=> (lowCnt == '0 && highCnt == '0));

endmodule

// File: rtl/drd_datapath.sv
module drd_datapath
  import drd_pkg::*;
#(
  parameter int NUM_STAGES = 7,
  parameter int LOW_DIV    = 2,
  parameter int HIGH_DIV   = 5,
  parameter int FINAL_DIV  = 5,
  localparam int FIN_W     = (FINAL_DIV > 1) ? $clog2(FINAL_DIV) : 1
) (
  input  logic                  clk,
  input  dpStrobe_t             strobe,
  output logic [NUM_STAGES:0]   tapVec,
  output logic                  finalLast
);

  logic [NUM_STAGES:1] stageTerm;
  logic [FIN_W-1:0]    finCnt;

  assign tapVec[0] = 1'b1;

  for (genvar k = 1; k <= NUM_STAGES; k++) begin : g_stage
    drd_decade_stage #(
      .LOW_DIV (LOW_DIV),
      .HIGH_DIV(HIGH_DIV)
    ) u_stage (
      .clk    (clk),
      .clear  (strobe.clear),
      .advance(tapVec[k-1]),
      .atTerm (stageTerm[k])
    );
    assign tapVec[k] = tapVec[k-1] & stageTerm[k];
  end

  assign finalLast = (finCnt == FIN_W'(FINAL_DIV - 1));

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      finCnt <= '0;
    end else if (strobe.step) begin
      finCnt <= finalLast ? '0 : finCnt + 1'b1;
    end
  end

  // R5
  fin_range_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    int'(finCnt) < FINAL_DIV);

  // R5
  fin_hold_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.step |=> $stable(finCnt));

endmodule

// File: rtl/drd_ctrl.sv
module drd_ctrl
  import drd_pkg::*;
#(
  parameter int NUM_STAGES = 7,
  localparam int SEL_W     = $clog2(NUM_STAGES + 1),
  localparam int PAD_N     = 1 << SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    rangeSel,
  input  logic [NUM_STAGES:0] tapVec,
  input  logic                finalLast,
  output dpStrobe_t           strobe,
  output logic                refTick
);

  logic [SEL_W-1:0] activeSel;
  logic [PAD_N-1:0] tapPad;
  logic             selTap;
  logic             wrap;

  // Codes beyond the last stage fall back to the slowest tap
  for (genvar i = 0; i < PAD_N; i++) begin : g_pad
    if (i <= NUM_STAGES) begin : g_real
      assign tapPad[i] = tapVec[i];
    end else begin : g_clamp
      assign tapPad[i] = tapVec[NUM_STAGES];
    end
  end

  assign selTap       = tapPad[activeSel];
  assign wrap         = selTap && finalLast;
  assign strobe.clear = rst;
  assign strobe.step  = selTap;

  always_ff @(posedge clk) begin
    if (rst) begin
      activeSel <= rangeSel;
      refTick   <= 1'b0;
    end else begin
      refTick <= wrap;
      if (wrap) begin
        activeSel <= rangeSel;
      end
    end
  end

  // R8
  tick_width_chk: assert property (@(posedge clk) disable iff (rst)
    refTick |=> !refTick);

  // R6
  sel_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && activeSel != $past(activeSel)) |-> refTick);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !refTick);

endmodule

// File: rtl/decade_range_divider.sv
module decade_range_divider
  import drd_pkg::*;
#(
  parameter int NUM_STAGES = 7,
  parameter int LOW_DIV    = 2,
  parameter int HIGH_DIV   = 5,
  parameter int FINAL_DIV  = 5,
  localparam int SEL_W     = $clog2(NUM_STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rangeSel,
  output logic             refTick
);

  dpStrobe_t           strobe;
  logic [NUM_STAGES:0] tapVec;
  logic                finalLast;

  drd_ctrl #(
    .NUM_STAGES(NUM_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rangeSel (rangeSel),
    .tapVec   (tapVec),
    .finalLast(finalLast),
    .strobe   (strobe),
    .refTick  (refTick)
  );

  drd_datapath #(
    .NUM_STAGES(NUM_STAGES),
    .LOW_DIV   (LOW_DIV),
    .HIGH_DIV  (HIGH_DIV),
    .FINAL_DIV (FINAL_DIV)
  ) u_datapath (
    .clk      (clk),
    .strobe   (strobe),
    .tapVec   (tapVec),
    .finalLast(finalLast)
  );

endmodule

// File: tb/decade_range_divider_test.sv
module decade_range_divider_test;

  localparam int STAGES = 3;
  localparam int SW     = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] rangeSel = '0;
  logic          refTick;

  always #5 clk = ~clk;

  decade_range_divider #(.NUM_STAGES(STAGES)) uut (
    .clk     (clk),
    .rst     (rst),
    .rangeSel(rangeSel),
    .refTick (refTick)
  );

  int      compared   = 0;
  int      mismatched = 0;
  int      tickCount  = 0;
  longint  edgeCnt    = 0;
  longint  expNext    = 0;
  logic [SW-1:0] selAtEdge = '0;
  logic [SW-1:0] modelSel  = '0;
  bit      fromReset = 1'b1;
  bit      lastTick  = 1'b0;
  bit      done      = 1'b0;

  function automatic longint pow10(input int c);
    longint r = 1;
    for (int i = 0; i < c; i++) r = r * 10;
    return r;
  endfunction

  // Edge index since reset release (1-based) and code seen at each edge
  always @(posedge clk) begin
    selAtEdge <= rangeSel;
    if (rst) edgeCnt <= 0;
    else     edgeCnt <= edgeCnt + 1;
  end

  // R1 R2 R3 R4 R5 R6 R7: tick edge predicted from code and tick position
  always @(negedge clk) begin
    string tag;
    longint p;
    if (rst) begin
      expNext   <= 5 * pow10(int'(rangeSel));
      modelSel  <= rangeSel;
      fromReset <= 1'b1;
      lastTick  <= 1'b0;
    end else begin
      if (fromReset)                 tag = "R7";
      else if (selAtEdge != modelSel) tag = "R6";
      else if (modelSel == '0)        tag = "R1";
      else                            tag = "R2";
      if (refTick) begin
        compared++;
        if (edgeCnt != expNext) begin
          mismatched++;
          $display("FAIL %s: tick at edge %0d, expected edge %0d (code %0d)",
                   tag, edgeCnt, expNext, modelSel);
        end
        // R8: one-cycle width
        if (lastTick) begin
          mismatched++;
          $display("FAIL R8: refTick high two cycles, actual 1 expected 0 at edge %0d", edgeCnt);
        end
        p = pow10(int'(selAtEdge));
        expNext   <= (edgeCnt / p + 5) * p;
        modelSel  <= selAtEdge;
        fromReset <= 1'b0;
        tickCount <= tickCount + 1;
      end else if (edgeCnt == expNext) begin
        compared++;
        mismatched++;
        $display("FAIL %s: no tick at edge %0d, actual 0 expected 1", tag, edgeCnt);
      end
      lastTick <= refTick;
    end
  end

  task automatic doReset(input int code);
    @(posedge clk); #2;
    rst = 1'b1;
    rangeSel = SW'(code);
    repeat (3) @(posedge clk);
    #2;
    // R8 R7: output quiet under reset
    compared++;
    if (refTick !== 1'b0) begin
      mismatched++;
      $display("FAIL R8: refTick during reset, actual %b expected 0", refTick);
    end
    rst = 1'b0;
  endtask

  task automatic waitTicks(input int n);
    int target;
    target = tickCount + n;
    wait (tickCount >= target);
    @(posedge clk); #2;
  endtask

  initial begin
    doReset(0);
    waitTicks(6);
    // Sweep every ordered pair of codes, changing mid-period
    for (int a = 0; a <= STAGES; a++) begin
      for (int b = 0; b <= STAGES; b++) begin
        rangeSel = SW'(a);
        waitTicks(1);
        repeat (3) @(posedge clk);
        #2;
        rangeSel = SW'(b);  // R6: held off until the next wrap
        waitTicks(2);
      end
    end
    // R7: mid-run resets with different codes
    doReset(2);
    waitTicks(3);
    doReset(3);
    waitTicks(2);
    doReset(1);
    waitTicks(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run hung, actual %0d ticks expected completion", tickCount);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule